// File: doc/BRIEF.md
# Flag-Chaining Byte ALU with Single-Bit Shifter

This block is the execute stage of a small 8-bit controller datapath. Each cycle it takes an operation code and two byte operands. It returns a result byte, a register write-enable and the next value of a zero/carry flag pair. Arithmetic, logical, parity-test and one-bit shift/rotate operations all share one output port. The flag pair lives inside the block and is updated at the clock edge of every accepted operation. The next-flag values are also driven out combinationally, so a surrounding pipeline can forward them.

The carry-extended operations let software build wider arithmetic out of bytes. The carry is folded into the sum or difference. The zero flag is chained, so after a multi-byte sequence Z reports whether the whole wide value is zero. Comparisons and parity tests change only the flags. The shifter moves by exactly one bit per operation, and the choice of fill bit gives logical, arithmetic, rotate and through-carry variants.

Top module: `zc_alu8`

## Requirements
- R1: While `rst_n` is low both flags read 0. After `rst_n` rises, accepted operations start updating the flags only once two clock edges of internal reset release have passed.
- R2: Code 0 (add) returns a+b and code 1 (add with carry) returns a+b+C. C is set when the true sum exceeds 255. For code 0, Z is set when the byte result is zero.
- R3: Codes 2 (subtract), 3 (subtract with borrow), 4 (compare) and 5 (compare with borrow) form a-b, or a-b-C for codes 3 and 5. C is set when the true difference is negative. For codes 2 and 4, Z is set when the byte result is zero.
- R4: For codes 1, 3 and 5, the next Z is 1 only when the byte result is zero and the current Z is 1.
- R5: Codes 6, 7 and 8 return a AND b, a OR b and a XOR b. C is cleared and Z is set on a zero result.
- R6: Code 9 (test) forms a AND b and sets C to the odd parity of that value and Z when it is zero. Code 10 (test with carry) sets C to that parity XOR the current C, and Z to the zero indication AND the current Z.
- R7: Codes 4, 5, 9 and 10 hold `res_we_o` low. Every other defined code drives it high while `op_valid` is high, and `res_we_o` is low whenever `op_valid` is low.
- R8: Codes 16 and 17 rotate `opnd_a` by one bit, left and right respectively. The bit that wraps around is also copied into C.
- R9: The one-bit shifts take `opnd_a` and ignore `opnd_b`. The fill bit is: 0 for codes 18 (left) and 22 (right); 1 for codes 19 (left) and 23 (right); the current C for codes 20 (left) and 24 (right); bit 0 of a for code 21 (left); bit 7 of a for code 25 (right). Left shifts put old bit 7 into C and right shifts put old bit 0 into C.
- R10: Code 19 always clears Z. Every other shift and rotate sets Z exactly when its result is zero.
- R11: Code 11 (build read) returns the parameter `BUILD_ID`, sets C to 1, and sets Z only if `BUILD_ID` is zero.
- R12: `z_next_o` and `c_next_o` show the flags that the current inputs would produce, and `z_o`/`c_o` take those values at the clock edge when `op_valid` is high. When `op_valid` is low, or for an undefined code (12–15 and 26–31), the flags keep their value, and undefined codes never raise `res_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation accepted this cycle; clock enable of the flag pair |
| op_code | input | 5 | Operation code |
| opnd_a | input | 8 | First operand; sole source for shifts and rotates |
| opnd_b | input | 8 | Second operand |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | Result should be written to the destination register |
| z_next_o | output | 1 | Zero flag the current operation produces |
| c_next_o | output | 1 | Carry flag the current operation produces |
| z_o | output | 1 | Registered zero flag |
| c_o | output | 1 | Registered carry flag |

## Verification
Two things meet in the same cycle. A chained operation reads the registered flags, and at the very clock edge that ends that cycle it writes the flag pair. Back-to-back operations therefore each depend on flags that were written one edge earlier. The bench provokes this with long random runs dense in carry-in, borrow, test-with-carry and through-carry shift codes, mixed with idle cycles and undefined codes. It also uses directed sequences that first preset Z=0/C=1 or Z=1/C=1 and then issue a chained operation whose byte result is zero. It judges each cycle against a bench model that carries its own copy of the flags, checking both the combinational next-flags and, one edge later, the registered pair.

// File: rtl/zc_alu8_pkg.sv
package zc_alu8_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBC = 5'd3,
    OP_CMP  = 5'd4,
    OP_CMPC = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_TST  = 5'd9,
    OP_TSTC = 5'd10,
    OP_BLD  = 5'd11,
    OP_RL   = 5'd16,
    OP_RR   = 5'd17,
    OP_SL0  = 5'd18,
    OP_SL1  = 5'd19,
    OP_SLA  = 5'd20,
    OP_SLX  = 5'd21,
    OP_SR0  = 5'd22,
    OP_SR1  = 5'd23,
    OP_SRA  = 5'd24,
    OP_SRX  = 5'd25
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  typedef enum logic [2:0] {
    FILL_ROT  = 3'd0,
    FILL_ZERO = 3'd1,
    FILL_ONE  = 3'd2,
    FILL_CY   = 3'd3,
    FILL_EXT  = 3'd4
  } fill_sel_e;

endpackage

// File: rtl/zc_alu8_rst_sync.sv
module zc_alu8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/zc_alu8_arith.sv
module zc_alu8_arith #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          is_zero
);
  logic [DW:0] ext;
  logic [DW:0] ci_ext;

  always_comb begin
    ci_ext = {{DW{1'b0}}, cin};
    if (sub) ext = {1'b0, a} - {1'b0, b} - ci_ext;
    else     ext = {1'b0, a} + {1'b0, b} + ci_ext;
  end

  assign res     = ext[DW-1:0];
  assign cout    = ext[DW];
  assign is_zero = (ext[DW-1:0] == '0);
endmodule

// File: rtl/zc_alu8_logic.sv
module zc_alu8_logic
  import zc_alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic_sel_e    sel,
  output logic [DW-1:0] res,
  output logic          parity,
  output logic          is_zero
);
  always_comb begin
    case (sel)
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = a & b;
    endcase
  end

  assign parity  = ^res;
  assign is_zero = (res == '0);
endmodule

// File: rtl/zc_alu8_shift.sv
module zc_alu8_shift
  import zc_alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  logic          left,
  input  fill_sel_e     fill_sel,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          is_zero
);
  logic fill;

  always_comb begin
    case (fill_sel)
      FILL_ROT:  fill = left ? a[DW-1] : a[0];
      FILL_ONE:  fill = 1'b1;
      FILL_CY:   fill = cin;
      FILL_EXT:  fill = left ? a[0] : a[DW-1];
      default:   fill = 1'b0;
    endcase
    if (left) begin
      res  = {a[DW-2:0], fill};
      cout = a[DW-1];
    end else begin
      res  = {fill, a[DW-1:1]};
      cout = a[0];
    end
  end

  assign is_zero = (res == '0);
endmodule

// File: rtl/zc_alu8.sv
module zc_alu8
  import zc_alu8_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [7:0]  BUILD_ID = 8'h5C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  input  logic [DW-1:0]   opnd_a,
  input  logic [DW-1:0]   opnd_b,
  output logic [DW-1:0]   res_o,
  output logic            res_we_o,
  output logic            z_next_o,
  output logic            c_next_o,
  output logic            z_o,
  output logic            c_o
);
  localparam logic [DW-1:0] BUILD_VAL = DW'(BUILD_ID);

  logic rst_sync_n;
  logic z_q, c_q;
  logic z_d, c_d;
  logic flag_en;

  // control decode
  logic       ar_cin, ar_sub;
  logic_sel_e lg_sel;
  logic       sh_left;
  fill_sel_e  sh_fill;

  // unit outputs
  logic [DW-1:0] ar_res, lg_res, sh_res;
  logic          ar_co, ar_zero;
  logic          lg_par, lg_zero;
  logic          sh_co, sh_zero;

  logic [DW-1:0] res_d;
  logic          wr_d;

  zc_alu8_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ar_cin  = 1'b0;
    ar_sub  = 1'b0;
    lg_sel  = LG_AND;
    sh_left = 1'b0;
    sh_fill = FILL_ZERO;
    case (op_code)
      OP_ADDC:                 ar_cin = c_q;
      OP_SUB, OP_CMP:          ar_sub = 1'b1;
      OP_SUBC, OP_CMPC: begin  ar_sub = 1'b1; ar_cin = c_q; end
      OP_OR:                   lg_sel = LG_OR;
      OP_XOR:                  lg_sel = LG_XOR;
      OP_RL:  begin sh_left = 1'b1; sh_fill = FILL_ROT;  end
      OP_SL0: begin sh_left = 1'b1; sh_fill = FILL_ZERO; end
      OP_SL1: begin sh_left = 1'b1; sh_fill = FILL_ONE;  end
      OP_SLA: begin sh_left = 1'b1; sh_fill = FILL_CY;   end
      OP_SLX: begin sh_left = 1'b1; sh_fill = FILL_EXT;  end
      OP_RR:                   sh_fill = FILL_ROT;
      OP_SR1:                  sh_fill = FILL_ONE;
      OP_SRA:                  sh_fill = FILL_CY;
      OP_SRX:                  sh_fill = FILL_EXT;
      default: ;
    endcase
  end

  zc_alu8_arith #(.DW(DW)) u_arith (
    .a(opnd_a), .b(opnd_b), .cin(ar_cin), .sub(ar_sub),
    .res(ar_res), .cout(ar_co), .is_zero(ar_zero)
  );

  zc_alu8_logic #(.DW(DW)) u_logic (
    .a(opnd_a), .b(opnd_b), .sel(lg_sel),
    .res(lg_res), .parity(lg_par), .is_zero(lg_zero)
  );

  zc_alu8_shift #(.DW(DW)) u_shift (
    .a(opnd_a), .cin(c_q), .left(sh_left), .fill_sel(sh_fill),
    .res(sh_res), .cout(sh_co), .is_zero(sh_zero)
  );

  // next-state: result, write-enable, flags
  always_comb begin
    res_d = '0;
    wr_d  = 1'b0;
    z_d   = z_q;
    c_d   = c_q;
    case (op_code)
      OP_ADD, OP_SUB: begin
        res_d = ar_res; wr_d = 1'b1; z_d = ar_zero; c_d = ar_co;
      end
      OP_ADDC, OP_SUBC: begin
        res_d = ar_res; wr_d = 1'b1; z_d = ar_zero & z_q; c_d = ar_co;
      end
      OP_CMP: begin
        res_d = ar_res; z_d = ar_zero; c_d = ar_co;
      end
      OP_CMPC: begin
        res_d = ar_res; z_d = ar_zero & z_q; c_d = ar_co;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_d = lg_res; wr_d = 1'b1; z_d = lg_zero; c_d = 1'b0;
      end
      OP_TST: begin
        res_d = lg_res; z_d = lg_zero; c_d = lg_par;
      end
      OP_TSTC: begin
        res_d = lg_res; z_d = lg_zero & z_q; c_d = lg_par ^ c_q;
      end
      OP_BLD: begin
        res_d = BUILD_VAL; wr_d = 1'b1; z_d = (BUILD_VAL == '0); c_d = 1'b1;
      end
      OP_SL1: begin
        res_d = sh_res; wr_d = 1'b1; z_d = 1'b0; c_d = sh_co;
      end
      OP_RL, OP_RR, OP_SL0, OP_SLA, OP_SLX,
      OP_SR0, OP_SR1, OP_SRA, OP_SRX: begin
        res_d = sh_res; wr_d = 1'b1; z_d = sh_zero; c_d = sh_co;
      end
      default: ;
    endcase
  end

  assign flag_en = op_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else if (flag_en) begin
      z_q <= z_d;
      c_q <= c_d;
    end
  end

  assign res_o    = res_d;
  assign res_we_o = op_valid & wr_d;
  assign z_next_o = z_d;
  assign c_next_o = c_d;
  assign z_o      = z_q;
  assign c_o      = c_q;
endmodule

// File: rtl/zc_alu8_chk.sv
module zc_alu8_chk
  import zc_alu8_pkg::*;
(
  input logic            clk,
  input logic            rst_ok,
  input logic            op_valid,
  input logic [OP_W-1:0] op_code,
  input logic            res_we_o,
  input logic            z_next_o,
  input logic            c_next_o,
  input logic            z_o,
  input logic            c_o
);
  logic is_flag_only;
  logic is_chained;
  logic is_bitwise;
  logic is_undef;

  always_comb begin
    is_flag_only = (op_code == OP_CMP) || (op_code == OP_CMPC) ||
                   (op_code == OP_TST) || (op_code == OP_TSTC);
    is_chained   = (op_code == OP_ADDC) || (op_code == OP_SUBC) ||
                   (op_code == OP_CMPC) || (op_code == OP_TSTC);
    is_bitwise   = (op_code == OP_AND) || (op_code == OP_OR) ||
                   (op_code == OP_XOR);
    is_undef     = ((op_code >= 5'd12) && (op_code <= 5'd15)) ||
                   (op_code >= 5'd26);
  end

  // R12: idle cycle keeps the flag pair
  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_valid |=> $stable({z_o, c_o}));

  // R12: accepted operation lands its next flags
  a_r12_flags_land: assert property (@(posedge clk) disable iff (!rst_ok)
    op_valid |=> (z_o == $past(z_next_o)) && (c_o == $past(c_next_o)));

  // R7: flag-only operations never request a write
  a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_ok)
    is_flag_only |-> !res_we_o);

  // R7: nothing written while idle
  a_r7_idle_no_write: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_valid |-> !res_we_o);

  // R4 / R6: a clear Z stays clear through a chained operation
  a_r4_zero_chain: assert property (@(posedge clk) disable iff (!rst_ok)
    (is_chained && !z_o) |-> !z_next_o);

  // R5: bitwise operations clear carry
  a_r5_carry_clear: assert property (@(posedge clk) disable iff (!rst_ok)
    is_bitwise |-> !c_next_o);

  // R10: shift-in-one never reports zero
  a_r10_sl1_nonzero: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_code == OP_SL1) |-> !z_next_o);

  // R11: build read forces carry
  a_r11_build_carry: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_code == OP_BLD) |-> c_next_o);

  // R12: undefined codes write nothing and propose the current flags
  a_r12_undef_inert: assert property (@(posedge clk) disable iff (!rst_ok)
    is_undef |-> (!res_we_o && (z_next_o == z_o) && (c_next_o == c_o)));
endmodule

bind zc_alu8 zc_alu8_chk u_chk (
  .clk      (clk),
  .rst_ok   (rst_sync_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .res_we_o (res_we_o),
  .z_next_o (z_next_o),
  .c_next_o (c_next_o),
  .z_o      (z_o),
  .c_o      (c_o)
);

// File: tb/zc_alu8_tb_top.sv
`timescale 1ns/1ps
module zc_alu8_tb_top;
  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [4:0] op_code;
  logic [7:0] opnd_a, opnd_b;
  logic [7:0] res_o;
  logic       res_we_o, z_next_o, c_next_o, z_o, c_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  logic mz, mc;

  localparam logic [7:0] BID = 8'h5C;

  zc_alu8 dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_o(res_o), .res_we_o(res_we_o),
    .z_next_o(z_next_o), .c_next_o(c_next_o), .z_o(z_o), .c_o(c_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // returns {writes, result[7:0], z, c}
  function automatic logic [10:0] model(input logic [4:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic z, input logic c);
    logic [8:0] w;
    logic [7:0] r;
    logic       we, nz, nc;
    we = 1'b0; r = 8'h00; nz = z; nc = c;
    case (op)
      5'd0:  begin w = a + b;      r = w[7:0]; we = 1; nc = w[8]; nz = (r == 0); end
      5'd1:  begin w = a + b + c;  r = w[7:0]; we = 1; nc = w[8]; nz = (r == 0) && z; end
      5'd2, 5'd4: begin
        nc = (a < b); r = a - b; we = (op == 5'd2); nz = (r == 0);
      end
      5'd3, 5'd5: begin
        nc = ({1'b0, a} < ({1'b0, b} + c)); r = a - b - c;
        we = (op == 5'd3); nz = (r == 0) && z;
      end
      5'd6:  begin r = a & b; we = 1; nc = 0; nz = (r == 0); end
      5'd7:  begin r = a | b; we = 1; nc = 0; nz = (r == 0); end
      5'd8:  begin r = a ^ b; we = 1; nc = 0; nz = (r == 0); end
      5'd9:  begin r = a & b; nc = ^r;       nz = (r == 0); end
      5'd10: begin r = a & b; nc = (^r) ^ c; nz = (r == 0) && z; end
      5'd11: begin r = BID;   we = 1; nc = 1; nz = (BID == 0); end
      5'd16: begin r = {a[6:0], a[7]}; we = 1; nc = a[7]; nz = (r == 0); end
      5'd17: begin r = {a[0], a[7:1]}; we = 1; nc = a[0]; nz = (r == 0); end
      5'd18: begin r = {a[6:0], 1'b0}; we = 1; nc = a[7]; nz = (r == 0); end
      5'd19: begin r = {a[6:0], 1'b1}; we = 1; nc = a[7]; nz = 0; end
      5'd20: begin r = {a[6:0], c};    we = 1; nc = a[7]; nz = (r == 0); end
      5'd21: begin r = {a[6:0], a[0]}; we = 1; nc = a[7]; nz = (r == 0); end
      5'd22: begin r = {1'b0, a[7:1]}; we = 1; nc = a[0]; nz = (r == 0); end
      5'd23: begin r = {1'b1, a[7:1]}; we = 1; nc = a[0]; nz = (r == 0); end
      5'd24: begin r = {c, a[7:1]};    we = 1; nc = a[0]; nz = (r == 0); end
      5'd25: begin r = {a[7], a[7:1]}; we = 1; nc = a[0]; nz = (r == 0); end
      default: ;
    endcase
    return {we, r, nz, nc};
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd0: return "R2";
      5'd1, 5'd3, 5'd5: return "R4";
      5'd2, 5'd4: return "R3";
      5'd6, 5'd7, 5'd8: return "R5";
      5'd9, 5'd10: return "R6";
      5'd11: return "R11";
      5'd16, 5'd17: return "R8";
      5'd19: return "R10";
      5'd18, 5'd20, 5'd21, 5'd22, 5'd23, 5'd24, 5'd25: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic do_op(input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic v);
    logic [10:0] e;
    @(negedge clk);
    chk("R12", "registered z", z_o, mz);
    chk("R12", "registered c", c_o, mc);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
    #1;
    e = model(op, a, b, mz, mc);
    chk("R7", "write enable", res_we_o, v & e[10]);
    if (e[10]) chk(tag_of(op), "result", res_o, e[9:2]);
    chk(tag_of(op), "next z", z_next_o, e[1]);
    chk(tag_of(op), "next c", c_next_o, e[0]);
    if (v) begin mz = e[1]; mc = e[0]; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; opnd_a = '0; opnd_b = '0;
    mz = 1'b0; mc = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "z in reset", z_o, 1'b0);
    chk("R1", "c in reset", c_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // op in the sync window must not land: R1
    op_valid = 1'b1; op_code = 5'd11;
    @(negedge clk);
    chk("R1", "z held during release", z_o, 1'b0);
    chk("R1", "c held during release", c_o, 1'b0);
    op_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R2: wrap with carry
    do_op(5'd0, 8'hFF, 8'h01, 1);
    chk("R2", "add wrap result", res_o, 8'h00);
    chk("R2", "add wrap c", c_next_o, 1'b1);
    // R3: borrow
    do_op(5'd2, 8'h00, 8'h01, 1);
    chk("R3", "sub borrow result", res_o, 8'hFF);
    chk("R3", "sub borrow c", c_next_o, 1'b1);
    // R7 / R3: compare equal
    do_op(5'd4, 8'h37, 8'h37, 1);
    chk("R7", "compare no write", res_we_o, 1'b0);
    chk("R3", "compare equal z", z_next_o, 1'b1);
    // R4: Z=0,C=1 then chained add to zero keeps Z clear
    do_op(5'd0, 8'h80, 8'h81, 1);
    do_op(5'd1, 8'hFF, 8'h00, 1);
    chk("R4", "chained add result", res_o, 8'h00);
    chk("R4", "chained add z", z_next_o, 1'b0);
    // R4: Z=1,C=1 then subtract with borrow to zero keeps Z set
    do_op(5'd0, 8'h80, 8'h80, 1);
    do_op(5'd3, 8'h01, 8'h00, 1);
    chk("R4", "chained sub z", z_next_o, 1'b1);
    chk("R4", "chained sub c", c_next_o, 1'b0);
    // R6: test with carry cancels parity
    do_op(5'd0, 8'h80, 8'h80, 1);
    do_op(5'd10, 8'h07, 8'hFF, 1);
    chk("R6", "testcy c", c_next_o, 1'b0);
    chk("R6", "testcy z", z_next_o, 1'b0);
    do_op(5'd9, 8'h07, 8'hFF, 1);
    chk("R6", "test parity c", c_next_o, 1'b1);
    // R10: shift in one
    do_op(5'd19, 8'h80, 8'h00, 1);
    chk("R10", "sl1 result", res_o, 8'h01);
    chk("R10", "sl1 z", z_next_o, 1'b0);
    // R9: arithmetic shifts
    do_op(5'd25, 8'h81, 8'h00, 1);
    chk("R9", "srx result", res_o, 8'hC0);
    do_op(5'd21, 8'h01, 8'hAA, 1);
    chk("R9", "slx result", res_o, 8'h03);
    // R8: rotate carry
    do_op(5'd17, 8'h01, 8'h00, 1);
    chk("R8", "rr result", res_o, 8'h80);
    chk("R8", "rr c", c_next_o, 1'b1);
    // R11
    do_op(5'd11, 8'h00, 8'h00, 1);
    chk("R11", "build result", res_o, BID);
    chk("R11", "build c", c_next_o, 1'b1);
    // R12: undefined code and idle
    do_op(5'd13, 8'h00, 8'h00, 1);
    do_op(5'd0, 8'hFF, 8'h01, 0);
    do_op(5'd28, 8'h12, 8'h34, 1);

    // random, biased toward chained codes
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] op;
      logic       v;
      if ($urandom_range(0, 3) == 0) begin
        case ($urandom_range(0, 5))
          0: op = 5'd1;  1: op = 5'd3;  2: op = 5'd5;
          3: op = 5'd10; 4: op = 5'd20; default: op = 5'd24;
        endcase
      end else begin
        op = 5'($urandom_range(0, 31));
      end
      v = ($urandom_range(0, 9) != 0);
      do_op(op, 8'($urandom_range(0, 255)),
            ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom_range(0, 255)), v);
    end
    do_op(5'd12, 8'h00, 8'h00, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule